// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns one 6-bit operand specifier into a final operand location for a 16-bit processor with eight general registers, register 7 being the program counter and register 6 the stack pointer. The specifier has a 3-bit addressing mode in its upper half and a 3-bit register number in its lower half. The result is one of two things. It is either a register operand, in which case no memory address exists, or a 16-bit memory effective address. On the way, the block may step a pointer register up or down, fetch a displacement word from the instruction stream, or fetch a pointer word through one level of indirection.

The sequencer is started by a one-cycle `start` pulse and answers with a one-cycle `done` pulse. It reads and writes the register bank through an external port; register reads return data in the same cycle. It reads memory through a request/acknowledge port that stays asserted until acknowledged. Operand data transfers, instruction decode and address translation are handled elsewhere.

Top module: `opaddr_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `rf_we` are low.
- R2: Mode 0 completes with `res_mem`=0 and `res_reg` equal to the specifier register. It performs no register write and no memory read.
- R3: Mode 1 completes with `res_mem`=1 and `res_ea` equal to the register contents. The register is left unchanged.
- R4: Mode 2 gives the register's old value as the address and then writes back the old value plus a step. The step is 1 for a byte operand (`byte_op`=1) on registers 0 to 5, and 2 otherwise. Registers 6 and 7 always step by 2.
- R5: Mode 3 reads one word at the register's old value and returns that word as the address. The register is then raised by 2, whatever the operand size.
- R6: Mode 4 lowers the register by the same step rule as R4, and the lowered value is the address.
- R7: Mode 5 lowers the register by 2, reads one word at the lowered value, and returns that word as the address.
- R8: Mode 6 reads a displacement word at the address held in register 7 and writes register 7 plus 2 back to register 7. It then adds the displacement to the specifier register as it stands after that update. With register 7, the sum is therefore relative to the advanced program counter.
- R9: Mode 7 does what mode 6 does, then reads one word at the sum and returns that word as the address.
- R10: All address and pointer arithmetic wraps modulo 2^16.
- R11: A memory request stays high with a stable address until `mem_ack` is seen, and no request is made while idle.
- R12: `done` lasts exactly one cycle per resolution, and `start` is ignored while a resolution is in progress. Modes 0, 1, 2 and 4 finish on the 2nd clock edge after `start` is sampled. With a memory latency of L extra cycles, modes 3 and 5 finish on edge 4+L, mode 6 on edge 6+L and mode 7 on edge 8+2L.
- R13: Each resolution makes exactly one register write in modes 2 to 7 and none in modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution (accepted only when idle) |
| spec_mode | input | 3 | Addressing mode of the specifier |
| spec_reg | input | 3 | Register number of the specifier |
| byte_op | input | 1 | 1 for a byte operand, 0 for a word operand |
| done | output | 1 | One-cycle completion pulse |
| res_mem | output | 1 | 1: `res_ea` is a memory address; 0: register operand |
| res_ea | output | 16 | Effective address (valid with `done` when `res_mem`=1) |
| res_reg | output | 3 | Register number of the resolved specifier |
| rf_raddr | output | 3 | Register bank read select |
| rf_rdata | input | 16 | Register bank read data (same cycle) |
| rf_we | output | 1 | Register bank write enable |
| rf_waddr | output | 3 | Register bank write select |
| rf_wdata | output | 16 | Register bank write data |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid with it |
| mem_rdata | input | 16 | Memory read data |

## Verification
Each result falls due at a fixed clock edge after `start` is sampled. Modes without memory traffic finish on edge 2. The memory modes finish on edge 4+L, 6+L or 8+2L, where L is the acknowledge latency set by the bench's memory responder. The bench counts falling edges from the `start` pulse to `done` and compares the count with that table. It samples results on falling edges only. It compares the register bank one falling edge after `done`, because the final pointer write lands on the edge that follows the pulse. It then confirms that `done` has dropped.

// File: rtl/opaddr_pkg.sv
`timescale 1ns/1ps
package opaddr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_PCFETCH, ST_DISP, ST_INDEX, ST_PTR
  } seq_state_t;

  localparam logic [2:0] M_REG  = 3'd0;
  localparam logic [2:0] M_DEF  = 3'd1;
  localparam logic [2:0] M_INC  = 3'd2;
  localparam logic [2:0] M_INCD = 3'd3;
  localparam logic [2:0] M_DEC  = 3'd4;
  localparam logic [2:0] M_DECD = 3'd5;
  localparam logic [2:0] M_IDX  = 3'd6;
  localparam logic [2:0] M_IDXD = 3'd7;
endpackage

// File: rtl/opaddr_calc.sv
`timescale 1ns/1ps
// Combinational pointer arithmetic for the register-based modes (0..5).
module opaddr_calc #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  logic [2:0]    mode,
  input  logic [RW-1:0] rnum,
  input  logic          byte_op,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] upd_val,
  output logic [DW-1:0] addr,
  output logic          wr_en,
  output logic          ptr_en
);
  import opaddr_pkg::*;

  localparam logic [RW-1:0] SP_R = RW'(SP_IDX);
  localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

  logic          unit_step;
  logic [DW-1:0] step, inc_val, dec_val;

  // Single steps only for byte operands on ordinary registers in modes 2/4
  assign unit_step = byte_op && (rnum != SP_R) && (rnum != PC_R) &&
                     ((mode == M_INC) || (mode == M_DEC));
  assign step    = unit_step ? DW'(1) : DW'(2);
  assign inc_val = base + step;
  assign dec_val = base - step;

  always_comb begin
    upd_val = '0;
    addr    = '0;
    wr_en   = 1'b0;
    ptr_en  = 1'b0;
    case (mode)
      M_DEF:  addr = base;
      M_INC:  begin addr = base;    upd_val = inc_val; wr_en = 1'b1; end
      M_INCD: begin addr = base;    upd_val = inc_val; wr_en = 1'b1; ptr_en = 1'b1; end
      M_DEC:  begin addr = dec_val; upd_val = dec_val; wr_en = 1'b1; end
      M_DECD: begin addr = dec_val; upd_val = dec_val; wr_en = 1'b1; ptr_en = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/opaddr_memport.sv
`timescale 1ns/1ps
// Holds a single memory read request until it is acknowledged.
module opaddr_memport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [DW-1:0] issue_addr,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic          got
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= issue_addr;
    end else if (mem_req && mem_ack) begin
      mem_req  <= 1'b0;
    end
  end

  assign got = mem_req && mem_ack;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/opaddr_seq.sv
`timescale 1ns/1ps
module opaddr_seq #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    spec_mode,
  input  logic [RW-1:0] spec_reg,
  input  logic          byte_op,
  output logic          done,
  output logic          res_mem,
  output logic [DW-1:0] res_ea,
  output logic [RW-1:0] res_reg,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import opaddr_pkg::*;

  localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

  seq_state_t    state;
  logic [2:0]    mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic [DW-1:0] disp_q;

  logic [DW-1:0] c_upd, c_addr, idx_sum, issue_addr;
  logic          c_wr, c_ptr, issue, got;

  assign rf_raddr = (state == ST_PCFETCH) ? PC_R : reg_q;
  assign idx_sum  = rf_rdata + disp_q;

  opaddr_calc #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_calc (
    .mode(mode_q), .rnum(reg_q), .byte_op(byte_q), .base(rf_rdata),
    .upd_val(c_upd), .addr(c_addr), .wr_en(c_wr), .ptr_en(c_ptr)
  );

  always_comb begin
    issue      = 1'b0;
    issue_addr = '0;
    case (state)
      ST_BASE:    begin issue = c_ptr;              issue_addr = c_addr;   end
      ST_PCFETCH: begin issue = 1'b1;               issue_addr = rf_rdata; end
      ST_INDEX:   begin issue = (mode_q == M_IDXD); issue_addr = idx_sum;  end
      default: ;
    endcase
  end

  opaddr_memport #(.DW(DW)) u_mem (
    .clk(clk), .rst(rst), .issue(issue), .issue_addr(issue_addr),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr), .got(got)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= '0;
      reg_q    <= '0;
      byte_q   <= 1'b0;
      disp_q   <= '0;
      done     <= 1'b0;
      res_mem  <= 1'b0;
      res_ea   <= '0;
      res_reg  <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mode_q <= spec_mode;
          reg_q  <= spec_reg;
          byte_q <= byte_op;
          state  <= ST_BASE;
        end
        ST_BASE: begin
          if (c_wr) begin
            rf_we    <= 1'b1;
            rf_waddr <= reg_q;
            rf_wdata <= c_upd;
          end
          if (mode_q >= M_IDX) state <= ST_PCFETCH;
          else if (c_ptr)      state <= ST_PTR;
          else begin
            done    <= 1'b1;
            res_mem <= (mode_q != M_REG);
            res_ea  <= c_addr;
            res_reg <= reg_q;
            state   <= ST_IDLE;
          end
        end
        ST_PCFETCH: begin
          rf_we    <= 1'b1;
          rf_waddr <= PC_R;
          rf_wdata <= rf_rdata + DW'(2);
          state    <= ST_DISP;
        end
        ST_DISP: if (got) begin
          disp_q <= mem_rdata;
          state  <= ST_INDEX;
        end
        ST_INDEX: begin
          if (mode_q == M_IDXD) state <= ST_PTR;
          else begin
            done    <= 1'b1;
            res_mem <= 1'b1;
            res_ea  <= idx_sum;
            res_reg <= reg_q;
            state   <= ST_IDLE;
          end
        end
        ST_PTR: if (got) begin
          done    <= 1'b1;
          res_mem <= 1'b1;
          res_ea  <= mem_rdata;
          res_reg <= reg_q;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Write tally since the last accepted start, used by the checks below
  logic [1:0] wr_cnt;
  always_ff @(posedge clk) begin
    if (rst) wr_cnt <= '0;
    else if (state == ST_IDLE && start) wr_cnt <= '0;
    else if (rf_we && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(mode_q) && $stable(reg_q)));

  // R11
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !done) |-> !mem_req);

  // R13
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (({1'b0, wr_cnt} + {2'b0, rf_we}) == ((mode_q >= M_INC) ? 3'd1 : 3'd0)));

  // R13
  write_single_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
endmodule

// File: tb/opaddr_seq_test.sv
`timescale 1ns/1ps
module opaddr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  spec_mode = '0;
  logic [2:0]  spec_reg = '0;
  logic        byte_op = 1'b0;
  logic        done, res_mem;
  logic [15:0] res_ea;
  logic [2:0]  res_reg, rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr;
  logic        rf_we, mem_req;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  opaddr_seq uut (
    .clk(clk), .rst(rst), .start(start), .spec_mode(spec_mode),
    .spec_reg(spec_reg), .byte_op(byte_op), .done(done), .res_mem(res_mem),
    .res_ea(res_ea), .res_reg(res_reg), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Register bank model
  logic [15:0] regs [8];
  logic [15:0] init_regs [8];
  logic        load_all = 1'b0;
  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk) begin
    if (load_all) for (int i = 0; i < 8; i++) regs[i] <= init_regs[i];
    else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  // Memory responder with configurable acknowledge latency
  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h3C5A;
  endfunction

  int          lat = 0;
  int          wcnt = 0;
  int          rd_total = 0;
  logic [15:0] rd_log [8];
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; wcnt <= 0; rd_total <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memf(mem_addr);
        rd_log[rd_total % 8] <= mem_addr;
        rd_total  <= rd_total + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // One resolution against the reference model; init_regs set by caller
  task automatic run(input logic [2:0] m, input logic [2:0] r, input bit b,
                     input int latency, input bit poke, input string tag);
    logic [15:0] er [8];
    logic [15:0] base, stp, nv, pc, d, s, eea;
    logic [15:0] eaddr [2];
    int          nrd, nwr, ecyc, cyc, rd0;
    bit          emem;
    string       rq;
    rq = (tag == "") ? mode_req(m) : tag;
    for (int i = 0; i < 8; i++) er[i] = init_regs[i];
    base = er[r];
    stp  = ((m == 3'd2 || m == 3'd4) && b && r < 3'd6) ? 16'd1 : 16'd2;
    emem = (m != 3'd0); eea = '0; nrd = 0; nwr = 1;
    case (m)
      3'd0: begin nwr = 0; ecyc = 2; end
      3'd1: begin eea = base; nwr = 0; ecyc = 2; end
      3'd2: begin eea = base; er[r] = base + stp; ecyc = 2; end
      3'd3: begin eaddr[0] = base; nrd = 1; eea = memf(base); er[r] = base + 16'd2;
                  ecyc = 4 + latency; end
      3'd4: begin nv = base - stp; er[r] = nv; eea = nv; ecyc = 2; end
      3'd5: begin nv = base - 16'd2; er[r] = nv; eaddr[0] = nv; nrd = 1;
                  eea = memf(nv); ecyc = 4 + latency; end
      default: begin
        pc = er[7]; d = memf(pc); er[7] = pc + 16'd2; s = er[r] + d;
        eaddr[0] = pc; nrd = 1;
        if (m == 3'd6) begin eea = s; ecyc = 6 + latency; end
        else begin eaddr[1] = s; nrd = 2; eea = memf(s); ecyc = 8 + 2 * latency; end
      end
    endcase

    @(negedge clk);
    lat = latency;
    load_all = 1'b1;
    @(negedge clk);
    load_all = 1'b0;
    rd0 = rd_total;
    spec_mode = m; spec_reg = r; byte_op = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      if (poke && cyc == 2) begin
        spec_mode = ~m; spec_reg = ~r; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R12", "done cycle", 16'(cyc), 16'(ecyc));
    chk(rq, "res_mem", {15'd0, res_mem}, {15'd0, emem});
    if (emem) chk(rq, "res_ea", res_ea, eea);
    else      chk(rq, "res_reg", {13'd0, res_reg}, {13'd0, r});
    chk("R11", "read count", 16'(rd_total - rd0), 16'(nrd));
    for (int k = 0; k < nrd && k < 2; k++)
      chk("R11", "read address", rd_log[(rd0 + k) % 8], eaddr[k]);
    @(negedge clk);
    chk("R12", "done drop", {15'd0, done}, 16'd0);
    for (int i = 0; i < 8; i++)
      chk((nwr != 0) ? "R13" : rq, "register", regs[i], er[i]);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R12", "no second done", {15'd0, done}, 16'd0);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "mem_req", {15'd0, mem_req}, 16'd0);
    chk("R1", "rf_we", {15'd0, rf_we}, 16'd0);
  endtask

  task automatic t_sweep(input bit b);
    logic [15:0] seed;
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 8; r++) begin
        seed = 16'h1000 + 16'(m) * 16'h0321 + 16'(r) * 16'h0457 + 16'(b);
        for (int i = 0; i < 8; i++) init_regs[i] = seed ^ (16'(i) * 16'h0F13);
        run(3'(m), 3'(r), b, (m + r) % 3, 1'b0, "");
      end
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) init_regs[i] = 16'h0000;
    run(3'd4, 3'd1, 1'b1, 0, 1'b0, "R10");   // 0000 - 1 -> FFFF
    run(3'd5, 3'd6, 1'b0, 1, 1'b0, "R10");   // 0000 - 2 -> FFFE
    for (int i = 0; i < 8; i++) init_regs[i] = 16'hFFFF;
    run(3'd2, 3'd3, 1'b1, 0, 1'b0, "R10");   // FFFF + 1 -> 0000
    run(3'd3, 3'd4, 1'b1, 2, 1'b0, "R10");   // FFFF + 2 -> 0001
    init_regs[7] = 16'h0000; init_regs[3] = 16'hF000;
    run(3'd6, 3'd3, 1'b0, 0, 1'b0, "R10");   // F000 + 3C5A wraps
    run(3'd6, 3'd7, 1'b0, 1, 1'b0, "R10");
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < 8; i++) init_regs[i] = 16'h2468 + 16'(i) * 16'h0101;
    run(3'd7, 3'd2, 1'b0, 1, 1'b1, "R12");
    run(3'd3, 3'd5, 1'b1, 2, 1'b1, "R12");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) init_regs[i] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_wrap();
    t_busy_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule